// File: doc/BRIEF.md
# Register-Programmed SPI Master Port

This block is a master-only synchronous serial port controlled through a small word-addressed register bus. Software sets the frame length (4 to 16 bits), the clock idle level and the sampling edge, and a two-stage bit-rate divider. It then writes transmit words into a data register. Each queued word is shifted out most significant bit first while the same number of bits is shifted in. Every received frame becomes one word that is read back from the same data address.

A status register shows whether the transmit queue has room, whether received data is waiting, and whether the port is busy. An enable bit gates frame starts. While the port is enabled, the configuration registers are locked. A loopback bit feeds the serial output straight back to the receiver. The slave-select and output-disable bits are stored and read back but change no timing.

Top module: `spi_port`

## Requirements
- R1: After reset the format register reads 0x0007, the control register reads 0x0000, the prescale register reads 0x0002, the status register reads 0x0002, the data address reads 0x0000, chip select is high and the serial clock is low.
- R2: The register addresses are 0 format, 1 control, 2 data, 3 status and 4 prescale. The format register holds frame length minus one in bits 3:0, a format code in bits 5:4 (stored only), the clock idle level in bit 6, the phase in bit 7 and a rate value in bits 15:8. A written length field below 3 is stored as 3.
- R3: The prescale register uses bits 7:0 and always holds an even value from 2 to 254. Bit 0 of a write is cleared, and a write that would store 0 stores 2.
- R4: One bit lasts prescale × (rate + 1) clock cycles, and the serial clock changes level after each half of that time.
- R5: The serial clock idles at the level of bit 6. With phase 0 the input is sampled on the first clock edge of each bit and the output changes on the second. With phase 1 the output changes on the first edge and the input is sampled on the second. Bits go out most significant bit first.
- R6: Each transmitted frame pushes exactly one received word, holding the frame's bits in its low bits with every unused upper bit zero.
- R7: Chip select is low for the whole of each frame. It stays low from one frame into the next when more data is queued, and goes high when the transmit queue is empty.
- R8: While control bit 1 (enable) is set, writes to the format and prescale registers are ignored and a control write changes only the enable bit.
- R9: Each queue holds 8 words. A write to a full transmit queue is dropped, and a frame received while the receive queue is full is dropped. Status bit 1 is set while the transmit queue is not full, bit 2 while the receive queue is not empty, and bit 4 while a frame is in progress or transmit data is queued. Other status bits read 0.
- R10: Control bit 0 (loopback) makes the receiver take the port's own serial output, and the external input is then ignored.
- R11: While enable is clear no frame starts and chip select stays high. Control bits 2 and 3 are stored and read back only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; pops the receive queue when the address is 2 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Register and status values change on the clock edge that takes a bus strobe. The bench drives strobes on falling edges and samples read data at the next falling edge, one edge after the effect. A frame starts one edge after enable. Its first clock edge follows after half a bit time, and the received word and the drop of busy appear on the edge of the last serial clock transition. The bench therefore polls the busy bit and only then compares the slave model's capture and the read data. Bit and half-bit times are measured as the time between serial clock transitions, in clock periods.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_FORMAT   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CONTROL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DATA     = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATUS   = 3'd3;
    localparam logic [ADDR_W-1:0] A_PRESCALE = 3'd4;

    // Field order follows the bit positions software decodes.
    typedef struct packed {
        logic [7:0] rate;
        logic       cpha;
        logic       cpol;
        logic [1:0] fmt;
        logic [3:0] size_m1;
    } fmt_reg_t;

    typedef struct packed {
        logic out_off;
        logic slave;
        logic enable;
        logic loopback;
    } ctl_reg_t;
endpackage

// File: rtl/spi_port_fifo.sv
`timescale 1ns/1ps
module spi_port_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t f_d, f_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full  = (f_q.count == CW'(DEPTH));
    assign empty = (f_q.count == '0);
    assign dout  = mem[f_q.rp];

    always_comb begin
        f_d     = f_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) f_d.wp = f_q.wp + 1'b1;
        if (do_pop)  f_d.rp = f_q.rp + 1'b1;
        if (do_push && !do_pop) f_d.count = f_q.count + 1'b1;
        else if (do_pop && !do_push) f_d.count = f_q.count - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[f_q.wp] <= din;
    end

    // R9: occupancy never passes the depth
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.count <= CW'(DEPTH));
    // R9: a push into a full queue without a pop leaves it full
    assert_full_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
endmodule

// File: rtl/spi_port_shifter.sv
`timescale 1ns/1ps
module spi_port_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         loopback,
    input  logic         cpol,
    input  logic         cpha,
    input  logic [3:0]   size_m1,
    input  logic [7:0]   rate,
    input  logic [7:0]   presc,
    input  logic         tx_valid,
    input  logic [W-1:0] tx_word,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_word,
    input  logic         miso,
    output logic         sclk,
    output logic         mosi,
    output logic         cs_n,
    output logic         active
);
    localparam int BW = $clog2(W + 1);

    typedef struct packed {
        logic          active;
        logic          cs_n;
        logic          sclk;
        logic          mosi;
        logic          half;
        logic [W-1:0]  tx_sr;
        logic [W-1:0]  rx_sr;
        logic [BW-1:0] bits_left;
        logic [15:0]   cnt;
    } shift_st_t;

    shift_st_t s_d, s_q;
    logic [15:0]   half_len;
    logic [BW-1:0] nbits;
    logic          start, miso_i;

    assign half_len = 16'(presc[7:1]) * (16'(rate) + 16'd1);
    assign nbits    = BW'(size_m1) + BW'(1);
    assign sclk     = s_q.sclk;
    assign mosi     = s_q.mosi;
    assign cs_n     = s_q.cs_n;
    assign active   = s_q.active;

    always_comb begin
        s_d     = s_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        start   = 1'b0;
        miso_i  = loopback ? s_q.mosi : miso;
        if (!s_q.active) begin
            s_d.sclk = cpol;
            s_d.cs_n = 1'b1;
            start    = enable && tx_valid;
        end else if (s_q.cnt == half_len - 16'd1) begin
            s_d.cnt  = '0;
            s_d.sclk = ~s_q.sclk;
            s_d.half = ~s_q.half;
            if (s_q.half == cpha) begin
                s_d.rx_sr = {s_q.rx_sr[W-2:0], miso_i};
            end else begin
                s_d.mosi  = s_q.tx_sr[W-1];
                s_d.tx_sr = {s_q.tx_sr[W-2:0], 1'b0};
            end
            if (s_q.half) begin
                s_d.bits_left = s_q.bits_left - 1'b1;
                if (s_q.bits_left == BW'(1)) begin
                    rx_push    = 1'b1;
                    s_d.active = 1'b0;
                    s_d.cs_n   = 1'b1;
                    start      = enable && tx_valid;
                end
            end
        end else begin
            s_d.cnt = s_q.cnt + 16'd1;
        end
        rx_word = s_d.rx_sr;
        if (start) begin
            tx_pop        = 1'b1;
            s_d.active    = 1'b1;
            s_d.cs_n      = 1'b0;
            s_d.cnt       = '0;
            s_d.half      = 1'b0;
            s_d.sclk      = cpol;
            s_d.bits_left = nbits;
            s_d.rx_sr     = '0;
            s_d.tx_sr     = tx_word << (BW'(W) - nbits);
            if (!cpha) begin
                s_d.mosi  = s_d.tx_sr[W-1];
                s_d.tx_sr = {s_d.tx_sr[W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.cs_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    // R5: with the idle level steady, an idle port holds the clock there
    assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.active && $stable(cpol)) |-> (s_q.sclk == cpol));
    // R7: select low exactly while a frame runs
    assert_cs_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |-> !s_q.cs_n);
    assert_cs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active |-> s_q.cs_n);
    // R6: a running frame always has between 1 and W bits left
    assert_bits_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |-> (s_q.bits_left != '0 && s_q.bits_left <= BW'(W)));
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
    import spi_port_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    typedef struct packed {
        fmt_reg_t   fmt;
        ctl_reg_t   ctl;
        logic [7:0] presc;
    } regs_t;

    regs_t r_d, r_q;
    logic tx_push, tx_pop, tx_full, tx_empty;
    logic rx_push, rx_pop, rx_full, rx_empty;
    logic busy, shift_active;
    logic [DATA_W-1:0] tx_head, rx_head, rx_word;
    logic [DATA_W-1:0] status;

    always_comb begin
        r_d     = r_q;
        tx_push = 1'b0;
        rx_pop  = bus_rd && (bus_addr == A_DATA) && !rx_empty;
        if (bus_wr) begin
            case (bus_addr)
                A_FORMAT: if (!r_q.ctl.enable) begin
                    r_d.fmt = fmt_reg_t'(bus_wdata);
                    if (bus_wdata[3:0] < 4'd3) r_d.fmt.size_m1 = 4'd3;
                end
                A_CONTROL: begin
                    if (!r_q.ctl.enable) r_d.ctl = ctl_reg_t'(bus_wdata[3:0]);
                    else                 r_d.ctl.enable = bus_wdata[1];
                end
                A_PRESCALE: if (!r_q.ctl.enable) begin
                    r_d.presc = (bus_wdata[7:1] == 7'd0) ? 8'd2 : {bus_wdata[7:1], 1'b0};
                end
                A_DATA:  tx_push = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q             <= '0;
            r_q.fmt.size_m1 <= 4'd7;
            r_q.presc       <= 8'd2;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy   = shift_active || !tx_empty;
    assign status = {11'd0, busy, 1'b0, !rx_empty, !tx_full, 1'b0};

    always_comb begin
        case (bus_addr)
            A_FORMAT:   bus_rdata = r_q.fmt;
            A_CONTROL:  bus_rdata = {12'd0, r_q.ctl};
            A_DATA:     bus_rdata = rx_empty ? '0 : rx_head;
            A_STATUS:   bus_rdata = status;
            A_PRESCALE: bus_rdata = {8'd0, r_q.presc};
            default:    bus_rdata = '0;
        endcase
    end

    spi_port_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata),
        .pop(tx_pop), .dout(tx_head), .full(tx_full), .empty(tx_empty));

    spi_port_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
        .pop(rx_pop), .dout(rx_head), .full(rx_full), .empty(rx_empty));

    spi_port_shifter #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .enable(r_q.ctl.enable), .loopback(r_q.ctl.loopback),
        .cpol(r_q.fmt.cpol), .cpha(r_q.fmt.cpha),
        .size_m1(r_q.fmt.size_m1), .rate(r_q.fmt.rate), .presc(r_q.presc),
        .tx_valid(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
        .active(shift_active));

    // R8: configuration holds steady while the port was enabled
    assert_lock_format_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(r_q.ctl.enable) |-> $stable(r_q.fmt));
    assert_lock_presc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(r_q.ctl.enable) |-> $stable(r_q.presc));
    // R3: prescale is even and non-zero
    assert_presc_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.presc[0] && r_q.presc != 8'd0));
    // R11: no frame begins while disabled
    assert_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(r_q.ctl.enable) && !$past(shift_active)) |-> !shift_active);
endmodule

// File: tb/sim_spi_port.sv
`timescale 1ns/1ps
module sim_spi_port;
    import spi_port_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        sclk, mosi, cs_n;
    logic        miso = 1'b0;

    int n_chk = 0, n_fail = 0;

    spi_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .spi_cs_n(cs_n));

    // Slave model: independent of the design, follows the mode rules
    logic [15:0] s_tx = 16'h0000, s_rx = '0, s_last = '0;
    logic        s_cpol = 1'b0, s_cpha = 1'b0, s_prev = 1'b0, s_act = 1'b0;
    int          s_n = 8, s_idx = 7, s_frames = 0, cs_rises = 0;

    always @(posedge cs_n) cs_rises++;

    always @(sclk or negedge cs_n) begin
        if (sclk !== s_prev) begin
            s_prev = sclk;
            if (s_act) begin
                if ((sclk != s_cpol) == !s_cpha) begin
                    s_rx = {s_rx[14:0], mosi};
                    if (s_cpha) begin
                        s_idx--;
                        if (s_idx < 0) begin s_last = s_rx; s_frames++; s_rx = '0; s_idx = s_n - 1; end
                    end
                end else begin
                    if (!s_cpha) begin
                        s_idx--;
                        if (s_idx < 0) begin s_last = s_rx; s_frames++; s_rx = '0; s_idx = s_n - 1; end
                    end
                    miso = s_tx[s_idx];
                end
                if (cs_n) s_act = 1'b0;
            end
        end else if (cs_n === 1'b0 && !s_act) begin
            s_act = 1'b1;
            s_idx = s_n - 1;
            s_rx  = '0;
            if (!s_cpha) miso = s_tx[s_idx];
        end
    end

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] st;
        st = 16'h0010;
        for (int i = 0; i < 20000; i++) begin
            bus_rd(A_STATUS, st);
            if (!st[4]) break;
        end
        chk("R9", "busy clears", {15'd0, st[4]}, 16'd0);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        bus_rd(A_FORMAT, v);   chk("R1", "format", v, 16'h0007);
        bus_rd(A_CONTROL, v);  chk("R1", "control", v, 16'h0000);
        bus_rd(A_PRESCALE, v); chk("R1", "prescale", v, 16'h0002);
        bus_rd(A_STATUS, v);   chk("R1", "status", v, 16'h0002);
        bus_rd(A_DATA, v);     chk("R1", "data", v, 16'h0000);
        chk("R1", "cs_n", {15'd0, cs_n}, 16'd1);
        chk("R1", "sclk", {15'd0, sclk}, 16'd0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        bus_wr(A_FORMAT, 16'hA5F1);  bus_rd(A_FORMAT, v);   chk("R2", "short length", v, 16'hA5F3);
        bus_wr(A_PRESCALE, 16'h0007); bus_rd(A_PRESCALE, v); chk("R3", "odd prescale", v, 16'h0006);
        bus_wr(A_PRESCALE, 16'h0000); bus_rd(A_PRESCALE, v); chk("R3", "zero prescale", v, 16'h0002);
        bus_wr(A_PRESCALE, 16'h01FF); bus_rd(A_PRESCALE, v); chk("R3", "max prescale", v, 16'h00FE);
        bus_wr(A_CONTROL, 16'h000C);  bus_rd(A_CONTROL, v);  chk("R11", "stored bits", v, 16'h000C);
        chk("R11", "cs_n idle", {15'd0, cs_n}, 16'd1);
        bus_wr(A_CONTROL, 16'h0000);
        bus_wr(A_FORMAT, 16'h0007);
        bus_wr(A_PRESCALE, 16'h0002);
    endtask

    task automatic t_lock();
        logic [15:0] v;
        bus_wr(A_FORMAT, 16'h0307);
        bus_wr(A_CONTROL, 16'h0002);
        bus_wr(A_FORMAT, 16'hFFFF);   bus_rd(A_FORMAT, v);   chk("R8", "format locked", v, 16'h0307);
        bus_wr(A_PRESCALE, 16'h0040); bus_rd(A_PRESCALE, v); chk("R8", "prescale locked", v, 16'h0002);
        bus_wr(A_CONTROL, 16'h000F);  bus_rd(A_CONTROL, v);  chk("R8", "control locked", v, 16'h0002);
        bus_wr(A_CONTROL, 16'h000D);  bus_rd(A_CONTROL, v);  chk("R8", "enable only", v, 16'h0000);
    endtask

    task automatic t_mode(input logic pol, input logic pha, input int n, input logic [15:0] word,
                          input logic [15:0] sword, input logic [7:0] rate, input logic [7:0] pre);
        logic [15:0] v, mask;
        int f0;
        mask = 16'((32'h1 << n) - 1);
        bus_wr(A_CONTROL, 16'h0000);
        s_cpol = pol; s_cpha = pha; s_n = n; s_tx = sword;
        bus_wr(A_FORMAT, {rate, pha, pol, 2'b00, 4'(n - 1)});
        bus_wr(A_PRESCALE, {8'd0, pre});
        bus_wr(A_DATA, word);
        f0 = s_frames;
        bus_wr(A_CONTROL, 16'h0002);
        wait_idle();
        chk("R5", "slave captured", s_last & mask, word & mask);
        bus_rd(A_DATA, v);
        chk("R6", "received word", v, sword & mask);
        chk("R6", "frames", 16'(s_frames - f0), 16'd1);
        chk("R5", "idle clock", {15'd0, sclk}, {15'd0, pol});
        chk("R7", "cs_n after", {15'd0, cs_n}, 16'd1);
        bus_wr(A_CONTROL, 16'h0000);
    endtask

    task automatic t_timing();
        logic [15:0] v;
        realtime t0, t1, t2;
        bus_wr(A_CONTROL, 16'h0000);
        s_cpol = 1'b0; s_cpha = 1'b0; s_n = 8; s_tx = 16'h0055;
        bus_wr(A_FORMAT, 16'h0207);
        bus_wr(A_PRESCALE, 16'h0004);
        bus_wr(A_DATA, 16'h00C3);
        bus_wr(A_CONTROL, 16'h0002);
        @(posedge sclk); t0 = $realtime;
        @(negedge sclk); t1 = $realtime;
        @(posedge sclk); t2 = $realtime;
        chk("R4", "half bit cycles", 16'(int'((t1 - t0) / 5.0)), 16'd6);
        chk("R4", "bit cycles", 16'(int'((t2 - t0) / 5.0)), 16'd12);
        wait_idle();
        bus_rd(A_DATA, v);
        chk("R4", "slow frame data", v, 16'h0055);
        bus_wr(A_CONTROL, 16'h0000);
    endtask

    task automatic t_b2b();
        logic [15:0] v;
        int f0;
        bus_wr(A_CONTROL, 16'h0000);
        s_cpol = 1'b0; s_cpha = 1'b0; s_n = 8; s_tx = 16'h0081;
        bus_wr(A_FORMAT, 16'h0007);
        bus_wr(A_PRESCALE, 16'h0002);
        bus_wr(A_DATA, 16'h0011);
        bus_wr(A_DATA, 16'h0022);
        f0 = s_frames;
        cs_rises = 0;
        bus_wr(A_CONTROL, 16'h0002);
        wait_idle();
        chk("R7", "one deselect for two frames", 16'(cs_rises), 16'd1);
        chk("R7", "frames", 16'(s_frames - f0), 16'd2);
        bus_rd(A_DATA, v); chk("R6", "first", v, 16'h0081);
        bus_rd(A_DATA, v); chk("R6", "second", v, 16'h0081);
        bus_wr(A_CONTROL, 16'h0000);
    endtask

    task automatic t_fifo_loop();
        logic [15:0] v;
        bus_wr(A_CONTROL, 16'h0001);
        s_cpol = 1'b0; s_cpha = 1'b0; s_n = 8; s_tx = 16'h00FF;
        bus_wr(A_FORMAT, 16'h0007);
        bus_wr(A_PRESCALE, 16'h0002);
        for (int i = 1; i <= 9; i++) bus_wr(A_DATA, 16'(i * 16'h11));
        bus_rd(A_STATUS, v); chk("R9", "tx full status", v, 16'h0010);
        repeat (40) @(negedge clk);
        chk("R11", "no frame while disabled", {15'd0, cs_n}, 16'd1);
        bus_wr(A_CONTROL, 16'h0003);
        wait_idle();
        bus_rd(A_STATUS, v); chk("R9", "rx ready status", v, 16'h0006);
        bus_wr(A_DATA, 16'h0099);
        wait_idle();
        for (int i = 1; i <= 8; i++) begin
            bus_rd(A_DATA, v);
            chk("R10", "loopback word", v, 16'(i * 16'h11));
        end
        bus_rd(A_STATUS, v); chk("R9", "drained status", v, 16'h0002);
        bus_wr(A_CONTROL, 16'h0000);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_lock();
        t_mode(1'b0, 1'b0, 8,  16'h00A5, 16'h003C, 8'd0, 8'd2);
        t_mode(1'b1, 1'b0, 16, 16'hBEEF, 16'h1234, 8'd1, 8'd4);
        t_mode(1'b0, 1'b1, 4,  16'hFFF9, 16'hFFF6, 8'd0, 8'd2);
        t_mode(1'b1, 1'b1, 12, 16'h0ABC, 16'h05A5, 8'd2, 8'd2);
        t_timing();
        t_b2b();
        t_fifo_loop();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule